// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Block

This block is the host-side register set of a classic eight-register serial port. A host reaches it over a simple synchronous bus: a 3-bit offset, separate read and write strobes, and one byte of data in each direction. Received characters arrive whole on a push port and wait in a receive queue. Characters the host writes leave whole on a transmit strobe. A single-cycle interrupt pulse tells the host when a receive or transmit-empty event has been flagged. Bit timing, baud generation, parity and framing sit outside this block. The divisor register is stored and can be read back, but nothing in this block uses it.

The offsets are: 0 data, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. Line control bit 7 swaps offsets 0 and 1 over to the two bytes of a 16-bit divisor. Modem control bit 4 selects internal loopback. In loopback, transmitted bytes go into the receive queue and the modem control outputs appear on the modem status inputs.

A read takes effect in the same cycle: read data is combinational from the state before the clock edge, and side effects apply at that edge. The transmit strobe and the interrupt pulse are registered, so they are high during the cycle that follows the access.

Top module: `uart_regfile`

## Requirements
- R1: After reset the registers read: identification 0xC1, line status 0x60, line control 0x03, modem control 0x08, modem status 0xB0, scratch 0x00, interrupt enable 0x00, divisor 0x000C. Scratch, line control and modem control read back the last byte written.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. Data and interrupt-enable accesses are then not performed.
- R3: A write to interrupt enable stores only bits 3:0, and reads return bits 7:4 as 0. Bit 0 enables receive interrupts and bit 1 enables transmit-empty interrupts.
- R4: In identification, bit 0 = 1 means nothing is pending, bit 1 is the transmit-empty cause and bit 2 is the receive cause. Bit 0 is 1 exactly when bits 2:1 are both 0. A read returns the value ORed with 0xC0 and then resets the register to 0x01.
- R5: Outside loopback, a pushed byte enters the receive queue and sets line status bit 0. It raises the receive cause and an interrupt only if receive interrupts are enabled and the receive cause is clear.
- R6: A data read returns the oldest queued byte and removes it. It clears the receive cause. Line status bit 0 clears when the queue becomes empty. An empty queue reads 0x00.
- R7: Outside loopback, a data write drives tx_valid high for one cycle with the byte on tx_byte, in the cycle after the write. If transmit-empty interrupts are enabled, it also sets the transmit-empty cause and pulses the interrupt.
- R8: In loopback (modem control bit 4), a data write does not drive tx_valid. It enters the receive queue only while the queue holds fewer than 64 bytes, then sets line status bit 0 and may raise the receive interrupt as in R5. Pushed bytes are ignored in this mode.
- R9: In loopback, modem status reads return bits 3:0 of the stored status, with bit 4 = RTS (modem control bit 1), bit 5 = DTR (bit 0), bit 6 = OUT1 (bit 2) and bit 7 = OUT2 (bit 3). Outside loopback, modem status reads return the stored status.
- R10: An interrupt-enable write applies the receive rule of R5 if line status bit 0 is set. If any of bits 3:0 differ from the old value, it also applies the transmit-empty rule of R7, using the new enables.
- R11: irq_pulse is high for exactly the one cycle after each access or push that raised a cause, and it is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| rx_push | input | 1 | Pushes rx_byte into the receive queue |
| rx_byte | input | 8 | Received character |
| tx_valid | output | 1 | One-cycle strobe for a transmitted character |
| tx_byte | output | 8 | Transmitted character |
| irq_pulse | output | 1 | One-cycle interrupt event |

## Verification
The checks assume that bus_rd and bus_wr are never high together, and that rx_push is never high in the same cycle as a bus access. The bench therefore makes exactly one access or push per two-cycle slot, and drives every strobe low between slots. Given those input rules, the checks treat the identification encoding, the match between line status bit 0 and a non-empty queue, and the queue bounds as invariants. The absence of a transmit strobe during loopback and the one-cycle return of identification to 0x01 after a read are checked in the same way.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int unsigned OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IDENT = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCTL  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR   = 3'd7;

  localparam logic [7:0] IDENT_IDLE  = 8'h01;
  localparam logic [7:0] IDENT_THR   = 8'h02;
  localparam logic [7:0] IDENT_RX    = 8'h04;
  localparam logic [7:0] IDENT_FILL  = 8'hC0;
  localparam logic [7:0] LSTAT_RST   = 8'h60;
  localparam logic [7:0] LCTL_RST    = 8'h03;
  localparam logic [7:0] MCTL_RST    = 8'h08;
  localparam logic [7:0] MSTAT_RST   = 8'hB0;

  // Raise a cause: the idle flag drops and the cause bit is set.
  function automatic logic [7:0] ident_raise(input logic [7:0] cur, input logic [7:0] cause);
    return (cur & ~IDENT_IDLE) | cause;
  endfunction

  // Drop a cause: when no cause remains, the idle flag returns.
  function automatic logic [7:0] ident_drop(input logic [7:0] cur, input logic [7:0] cause);
    logic [7:0] t;
    t = cur & ~cause;
    return (t == 8'h00) ? IDENT_IDLE : t;
  endfunction

  // Loopback view of modem status: outputs mapped onto the upper four inputs.
  function automatic logic [7:0] loop_mstat(input logic [7:0] stored, input logic [7:0] mctl);
    return {mctl[3], mctl[2], mctl[0], mctl[1], stored[3:0]};
  endfunction

  // True when any enable bit changes.
  function automatic logic ien_changed(input logic [3:0] old_v, input logic [7:0] new_v);
    return (old_v ^ new_v[3:0]) != 4'h0;
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign count_o = cnt;
  assign dout_o  = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_next(wr_ptr);
      if (pop_i)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push_i |-> !full_o); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o); // R6
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en_i,
  input  logic       thr_en_i,
  input  logic       rx_evt_i,
  input  logic       thr_evt_i,
  input  logic       rx_ack_i,
  input  logic       ident_rd_i,
  output logic [7:0] ident_o,
  output logic       irq_o
);
  logic [7:0] ident_q, ident_d;
  logic       rx_fire, thr_fire;

  always_comb begin
    ident_d = ident_q;
    if (ident_rd_i) ident_d = IDENT_IDLE;
    if (rx_ack_i)   ident_d = ident_drop(ident_d, IDENT_RX);
    rx_fire  = rx_evt_i && rx_en_i && !ident_d[2];
    if (rx_fire)    ident_d = ident_raise(ident_d, IDENT_RX);
    thr_fire = thr_evt_i && thr_en_i;
    if (thr_fire)   ident_d = ident_raise(ident_d, IDENT_THR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ident_q <= IDENT_IDLE;
      irq_o   <= 1'b0;
    end else begin
      ident_q <= ident_d;
      irq_o   <= rx_fire || thr_fire;
    end
  end

  assign ident_o = ident_q;

  AST_IDENT_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) ident_q[0] == (ident_q[2:1] == 2'b00)); // R4
  AST_IDENT_RD_RESETS: assert property (@(posedge clk) disable iff (!rst_n) (ident_rd_i && !rx_evt_i && !thr_evt_i) |=> (ident_q == IDENT_IDLE)); // R4
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> !ident_q[0]); // R11
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int unsigned RXQ_DEPTH = 64,
  parameter logic [15:0] DIV_RST   = 16'd12,
  localparam int unsigned CW       = $clog2(RXQ_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       irq_pulse
);
  logic [3:0]  ien_q;
  logic [7:0]  lctl_q, mctl_q, scr_q;
  logic [15:0] div_q;
  logic        rx_avail_q;

  logic        latch_mode, loop_mode;
  logic        wr_data, rd_data, wr_ien, wr_dlo, wr_dhi, rd_ident;
  logic        ext_push, lb_push, q_push, q_pop;
  logic [7:0]  q_din, q_dout;
  logic [CW-1:0] q_count;
  logic        q_empty, q_full;
  logic [3:0]  ien_eff;
  logic        rx_evt, thr_evt;
  logic [7:0]  ident;

  assign latch_mode = lctl_q[7];
  assign loop_mode  = mctl_q[4];
  assign wr_data  = bus_wr && (bus_addr == OFS_DATA) && !latch_mode;
  assign rd_data  = bus_rd && (bus_addr == OFS_DATA) && !latch_mode;
  assign wr_ien   = bus_wr && (bus_addr == OFS_IEN)  && !latch_mode;
  assign wr_dlo   = bus_wr && (bus_addr == OFS_DATA) &&  latch_mode;
  assign wr_dhi   = bus_wr && (bus_addr == OFS_IEN)  &&  latch_mode;
  assign rd_ident = bus_rd && (bus_addr == OFS_IDENT);

  assign ext_push = rx_push && !loop_mode && !q_full;
  assign lb_push  = wr_data && loop_mode && !q_full;
  assign q_push   = ext_push || lb_push;
  assign q_din    = loop_mode ? bus_wdata : rx_byte;
  assign q_pop    = rd_data && !q_empty;

  assign ien_eff  = wr_ien ? bus_wdata[3:0] : ien_q;
  assign rx_evt   = q_push || (wr_ien && rx_avail_q);
  assign thr_evt  = (wr_data && !loop_mode) || (wr_ien && ien_changed(ien_q, bus_wdata));

  uart_rx_fifo #(.DEPTH(RXQ_DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_i(q_push), .din_i(q_din), .pop_i(q_pop),
    .dout_o(q_dout), .count_o(q_count), .empty_o(q_empty), .full_o(q_full)
  );

  uart_irq_ident u_ident (
    .clk(clk), .rst_n(rst_n),
    .rx_en_i(ien_eff[0]), .thr_en_i(ien_eff[1]),
    .rx_evt_i(rx_evt), .thr_evt_i(thr_evt),
    .rx_ack_i(rd_data), .ident_rd_i(rd_ident),
    .ident_o(ident), .irq_o(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q      <= 4'h0;
      lctl_q     <= LCTL_RST;
      mctl_q     <= MCTL_RST;
      scr_q      <= 8'h00;
      div_q      <= DIV_RST;
      rx_avail_q <= 1'b0;
      tx_valid   <= 1'b0;
      tx_byte    <= 8'h00;
    end else begin
      if (wr_ien) ien_q <= bus_wdata[3:0];
      if (bus_wr && bus_addr == OFS_LCTL) lctl_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_MCTL) mctl_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_SCR)  scr_q  <= bus_wdata;
      if (wr_dlo) div_q[7:0]  <= bus_wdata;
      if (wr_dhi) div_q[15:8] <= bus_wdata;
      if (q_push) rx_avail_q <= 1'b1;
      else if (rd_data && q_count <= CW'(1)) rx_avail_q <= 1'b0;
      tx_valid <= wr_data && !loop_mode;
      if (wr_data && !loop_mode) tx_byte <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DATA:  bus_rdata = latch_mode ? div_q[7:0]  : q_dout;
        OFS_IEN:   bus_rdata = latch_mode ? div_q[15:8] : {4'h0, ien_q};
        OFS_IDENT: bus_rdata = ident | IDENT_FILL;
        OFS_LCTL:  bus_rdata = lctl_q;
        OFS_MCTL:  bus_rdata = mctl_q;
        OFS_LSTAT: bus_rdata = {LSTAT_RST[7:1], rx_avail_q};
        OFS_MSTAT: bus_rdata = loop_mode ? loop_mstat(MSTAT_RST, mctl_q) : MSTAT_RST;
        OFS_SCR:   bus_rdata = scr_q;
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  AST_RX_FLAG_MATCHES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n) rx_avail_q == !q_empty); // R6
  AST_NO_TX_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |-> !$past(loop_mode)); // R8
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tx_valid |=> !tx_valid || $past(bus_wr)); // R7
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R11
endmodule

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  localparam int NV = 49;
  localparam logic [1:0] OPW = 2'd0, OPR = 2'd1, OPP = 2'd2;

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic       irq;
    logic       tx;
  } vec_t;

  function automatic vec_t mk(logic [1:0] op, logic [2:0] a, logic [7:0] d,
                              logic [7:0] e, logic i, logic t);
    return '{op: op, addr: a, data: d, exp: e, irq: i, tx: t};
  endfunction

  localparam vec_t VEC [NV] = '{
    mk(OPW,3'd7,8'h5A,8'h00,1'b0,1'b0), // R1
    mk(OPR,3'd7,8'h00,8'h5A,1'b0,1'b0), // R1
    mk(OPR,3'd3,8'h00,8'h03,1'b0,1'b0), // R1
    mk(OPR,3'd4,8'h00,8'h08,1'b0,1'b0), // R1
    mk(OPR,3'd5,8'h00,8'h60,1'b0,1'b0), // R1
    mk(OPR,3'd6,8'h00,8'hB0,1'b0,1'b0), // R1
    mk(OPR,3'd2,8'h00,8'hC1,1'b0,1'b0), // R4
    mk(OPW,3'd3,8'h83,8'h00,1'b0,1'b0), // R2
    mk(OPR,3'd0,8'h00,8'h0C,1'b0,1'b0), // R2
    mk(OPR,3'd1,8'h00,8'h00,1'b0,1'b0), // R2
    mk(OPW,3'd0,8'h34,8'h00,1'b0,1'b0), // R2
    mk(OPW,3'd1,8'h12,8'h00,1'b0,1'b0), // R2
    mk(OPR,3'd0,8'h00,8'h34,1'b0,1'b0), // R2
    mk(OPR,3'd1,8'h00,8'h12,1'b0,1'b0), // R2
    mk(OPW,3'd3,8'h03,8'h00,1'b0,1'b0), // R1
    mk(OPW,3'd1,8'h01,8'h00,1'b0,1'b0), // R10
    mk(OPR,3'd1,8'h00,8'h01,1'b0,1'b0), // R3
    mk(OPP,3'd0,8'h41,8'h00,1'b1,1'b0), // R5
    mk(OPP,3'd0,8'h42,8'h00,1'b0,1'b0), // R5
    mk(OPR,3'd5,8'h00,8'h61,1'b0,1'b0), // R5
    mk(OPR,3'd2,8'h00,8'hC4,1'b0,1'b0), // R4
    mk(OPP,3'd0,8'h43,8'h00,1'b1,1'b0), // R5
    mk(OPR,3'd0,8'h00,8'h41,1'b0,1'b0), // R6
    mk(OPR,3'd0,8'h00,8'h42,1'b0,1'b0), // R6
    mk(OPR,3'd5,8'h00,8'h61,1'b0,1'b0), // R6
    mk(OPR,3'd0,8'h00,8'h43,1'b0,1'b0), // R6
    mk(OPR,3'd5,8'h00,8'h60,1'b0,1'b0), // R6
    mk(OPR,3'd0,8'h00,8'h00,1'b0,1'b0), // R6
    mk(OPW,3'd1,8'h03,8'h00,1'b1,1'b0), // R10
    mk(OPR,3'd2,8'h00,8'hC2,1'b0,1'b0), // R10
    mk(OPW,3'd0,8'h55,8'h00,1'b1,1'b1), // R7
    mk(OPR,3'd1,8'h00,8'h03,1'b0,1'b0), // R3
    mk(OPW,3'd1,8'h03,8'h00,1'b0,1'b0), // R10
    mk(OPW,3'd1,8'hF3,8'h00,1'b0,1'b0), // R3
    mk(OPR,3'd1,8'h00,8'h03,1'b0,1'b0), // R3
    mk(OPR,3'd2,8'h00,8'hC2,1'b0,1'b0), // R7
    mk(OPW,3'd4,8'h1F,8'h00,1'b0,1'b0), // R9
    mk(OPR,3'd4,8'h00,8'h1F,1'b0,1'b0), // R1
    mk(OPR,3'd6,8'h00,8'hF0,1'b0,1'b0), // R9
    mk(OPW,3'd4,8'h11,8'h00,1'b0,1'b0), // R9
    mk(OPR,3'd6,8'h00,8'h20,1'b0,1'b0), // R9
    mk(OPP,3'd0,8'h77,8'h00,1'b0,1'b0), // R8
    mk(OPR,3'd5,8'h00,8'h60,1'b0,1'b0), // R8
    mk(OPW,3'd0,8'h66,8'h00,1'b1,1'b0), // R8
    mk(OPR,3'd5,8'h00,8'h61,1'b0,1'b0), // R8
    mk(OPR,3'd0,8'h00,8'h66,1'b0,1'b0), // R8
    mk(OPR,3'd5,8'h00,8'h60,1'b0,1'b0), // R8
    mk(OPW,3'd4,8'h08,8'h00,1'b0,1'b0), // R9
    mk(OPR,3'd6,8'h00,8'hB0,1'b0,1'b0)  // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, rx_push = 1'b0;
  logic [7:0] bus_wdata = '0, rx_byte = '0;
  logic [7:0] bus_rdata, tx_byte;
  logic tx_valid, irq_pulse;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq_pulse(irq_pulse)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  logic seen_irq, seen_tx;
  logic [7:0] seen_txb;

  task automatic do_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    seen_irq = irq_pulse; seen_tx = tx_valid; seen_txb = tx_byte;
  endtask

  task automatic do_push(logic [7:0] d);
    @(negedge clk);
    rx_byte = d; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
    seen_irq = irq_pulse; seen_tx = tx_valid; seen_txb = tx_byte;
  endtask

  task automatic do_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    seen_irq = irq_pulse;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    apply_reset();

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OPW: begin
          do_wr(VEC[i].addr, VEC[i].data);
          chk($sformatf("vec%0d irq R11", i), {7'd0, seen_irq}, {7'd0, VEC[i].irq});
          chk($sformatf("vec%0d tx_valid R7", i), {7'd0, seen_tx}, {7'd0, VEC[i].tx});
          if (VEC[i].tx) chk($sformatf("vec%0d tx_byte R7", i), seen_txb, VEC[i].data);
        end
        OPP: begin
          do_push(VEC[i].data);
          chk($sformatf("vec%0d irq R5", i), {7'd0, seen_irq}, {7'd0, VEC[i].irq});
        end
        default: begin
          do_rd(VEC[i].addr, rv);
          chk($sformatf("vec%0d rdata R1-map", i), rv, VEC[i].exp);
        end
      endcase
    end

    // R1: reset state after a second reset.
    apply_reset();
    do_rd(3'd1, rv); chk("R1 ien reset", rv, 8'h00);
    do_rd(3'd2, rv); chk("R1 ident reset", rv, 8'hC1);
    do_rd(3'd3, rv); chk("R1 lctl reset", rv, 8'h03);
    do_rd(3'd4, rv); chk("R1 mctl reset", rv, 8'h08);
    do_rd(3'd5, rv); chk("R1 lstat reset", rv, 8'h60);
    do_rd(3'd6, rv); chk("R1 mstat reset", rv, 8'hB0);
    do_rd(3'd7, rv); chk("R1 scratch reset", rv, 8'h00);
    do_wr(3'd3, 8'h80);
    do_rd(3'd0, rv); chk("R1 divisor low reset", rv, 8'h0C);
    do_rd(3'd1, rv); chk("R1 divisor high reset", rv, 8'h00);
    do_wr(3'd3, 8'h03);

    // R10: enable write with data already queued raises the receive cause.
    do_push(8'h99);
    chk("R5 push with rx disabled no irq", {7'd0, seen_irq}, 8'h00);
    do_wr(3'd1, 8'h01);
    chk("R10 ien write with data pulses", {7'd0, seen_irq}, 8'h01);
    @(negedge clk);
    chk("R11 pulse lasts one cycle", {7'd0, irq_pulse}, 8'h00);
    do_rd(3'd2, rv); chk("R10 ident after ien write", rv, 8'hC4);
    do_rd(3'd2, rv); chk("R4 ident cleared by read", rv, 8'hC1);
    do_rd(3'd0, rv); chk("R6 queued byte", rv, 8'h99);

    // R8: loopback queue accepts at most 64 bytes.
    do_wr(3'd4, 8'h10);
    for (int k = 0; k < 65; k++) begin
      do_wr(3'd0, 8'(k + 1));
      if (k == 0) chk("R8 first loop write irq", {7'd0, seen_irq}, 8'h01);
      if (k == 1) chk("R5 cause already set no irq", {7'd0, seen_irq}, 8'h00);
      if (seen_tx) chk("R8 no tx in loopback", {7'd0, seen_tx}, 8'h00);
    end
    for (int k = 0; k < 64; k++) begin
      do_rd(3'd0, rv);
      if (rv !== 8'(k + 1)) chk("R8 loop queue order", rv, 8'(k + 1));
    end
    checks++;
    do_rd(3'd5, rv); chk("R8 queue drained, 65th dropped", rv, 8'h60);
    do_rd(3'd0, rv); chk("R6 empty read zero", rv, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule